// File: doc/BRIEF.md
# Shared-Level Registry Bank

This block is one bank of a shared second-level cache in which the data array doubles as the coherence directory. Every word carries a single state flag. A word in the Valid state holds its current data. A word in the Registered state holds, in the low bits of its data slot, the id of the one core that owns the up-to-date copy. No sharer list exists anywhere. Only the single current owner is remembered for each word.

Private caches send four kinds of request: a read, a registration, a write-back and a reserved code that is handled as a read. A read of a Valid word is answered with the data. A read of a Registered word is answered with a forward response that names the owner, and the fabric uses it to pull the data straight from that owner's cache. A registration makes the requester the owner and is acknowledged. It sends no message to any earlier owner, because software guarantees freedom from races. A write-back puts the data back and returns the word to Valid. Each word keeps its own state, so neighbouring words can be owned by different cores or be Valid.

Top module: `registry_bank`

## Requirements
- R1: While `rst` is high, `resp_valid` and `req_ready` are low. `req_ready` is high from the first clock edge that samples `rst` low.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. Exactly two edges later `resp_valid` is high for one cycle. Responses come out in acceptance order, one per accepted request.
- R3: A write-back (`req_kind` = 2) stores `req_data` and sets the word Valid. Its response has kind ACK (`resp_kind` = 1), `resp_owner` equal to the requester and `resp_data` equal to 0.
- R4: A read (`req_kind` = 0, or the reserved code 3) of a Valid word gives a response of kind DATA (`resp_kind` = 0) that carries the stored word in `resp_data`, with `resp_owner` = 0.
- R5: A registration (`req_kind` = 1) sets the word Registered with the requester as owner. Its response has kind ACK, with `resp_owner` equal to the requester and `resp_data` = 0.
- R6: A read of a Registered word gives a response of kind FWD (`resp_kind` = 2). In it, `resp_owner` is the owner id, `resp_core` and `resp_addr` echo the requester and the address, and `resp_data` is 0.
- R7: A registration by the current owner is acknowledged and leaves the owner unchanged. Later reads still forward to that core.
- R8: A registration by a different core replaces the owner id. Later reads forward to the new core.
- R9: The state and contents of each word are independent of every other word. Registering one word does not change what a read of any other word returns.
- R10: A request accepted in the cycle right after a request to the same word sees that earlier request's effect.
- R11: A cycle with `req_valid` low produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_kind | input | 2 | 0 read, 1 register, 2 write-back, 3 read |
| req_core | input | CORE_W | Requesting core id |
| req_addr | input | ADDR_W | Word index within the bank |
| req_data | input | DATA_W | Write-back data |
| resp_valid | output | 1 | Response present |
| resp_kind | output | 2 | 0 DATA, 1 ACK, 2 FWD |
| resp_core | output | CORE_W | Requester this response belongs to |
| resp_owner | output | CORE_W | Owner for FWD, requester for ACK, 0 for DATA |
| resp_addr | output | ADDR_W | Word index of the request |
| resp_data | output | DATA_W | Word data for DATA, else 0 |

## Verification
The hardest case to reach is a dependent pair: a registration or write-back followed in the very next cycle by a read of the same word. This is where the read-before-write ordering of the storage could return a stale owner or stale data. The bench issues requests every cycle with no idle cycle between them. It sweeps a small bank through write-back, read, alternating registration, re-registration and owner change. It places same-word pairs back to back and checks every response against a model of word states kept in request order.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [1:0] {
    RQ_READ = 2'd0,
    RQ_REG  = 2'd1,
    RQ_WB   = 2'd2,
    RQ_RSV  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    RS_DATA = 2'd0,
    RS_ACK  = 2'd1,
    RS_FWD  = 2'd2
  } resp_kind_e;
endpackage

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int NWORDS = 64,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic              wr_reg,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_reg
);
  // Data array: no reset, read-first, so block RAM can be inferred.
  logic [DATA_W-1:0] mem [NWORDS];
  logic [NWORDS-1:0] reg_flag;

  always_ff @(posedge clk) begin
    if (en) begin
      if (wr_en) mem[addr] <= wr_data;
      rd_data <= mem[addr];
    end
  end

  // One state flag per word; set = Registered, clear = Valid.
  for (genvar w = 0; w < NWORDS; w++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        reg_flag[w] <= 1'b0;
      else if (en && wr_en && addr == ADDR_W'(w))
        reg_flag[w] <= wr_reg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_reg <= 1'b0;
    else if (en) rd_reg <= reg_flag[addr];
  end
endmodule

// File: rtl/regbank_resp.sv
module regbank_resp
  import regbank_pkg::*;
#(
  parameter int CORE_W = 6,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p_valid,
  input  logic [1:0]        p_kind,
  input  logic [CORE_W-1:0] p_core,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic              p_reg,
  input  logic [DATA_W-1:0] p_word,
  output logic              resp_valid,
  output logic [1:0]        resp_kind,
  output logic [CORE_W-1:0] resp_core,
  output logic [CORE_W-1:0] resp_owner,
  output logic [ADDR_W-1:0] resp_addr,
  output logic [DATA_W-1:0] resp_data
);
  logic              is_upd;
  logic [1:0]        n_kind;
  logic [CORE_W-1:0] n_owner;
  logic [DATA_W-1:0] n_data;

  always_comb begin
    is_upd  = (p_kind == RQ_REG) || (p_kind == RQ_WB);
    n_kind  = RS_DATA;
    n_owner = '0;
    n_data  = '0;
    if (is_upd) begin
      n_kind  = RS_ACK;
      n_owner = p_core;
    end else if (p_reg) begin
      n_kind  = RS_FWD;
      n_owner = p_word[CORE_W-1:0];
    end else begin
      n_data  = p_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_kind  <= RS_DATA;
      resp_core  <= '0;
      resp_owner <= '0;
      resp_addr  <= '0;
      resp_data  <= '0;
    end else begin
      resp_valid <= p_valid;
      if (p_valid) begin
        resp_kind  <= n_kind;
        resp_core  <= p_core;
        resp_owner <= n_owner;
        resp_addr  <= p_addr;
        resp_data  <= n_data;
      end
    end
  end
endmodule

// File: rtl/registry_bank.sv
module registry_bank
  import regbank_pkg::*;
#(
  parameter int NWORDS = 64,
  parameter int CORE_W = 6,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [CORE_W-1:0] req_core,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              resp_valid,
  output logic [1:0]        resp_kind,
  output logic [CORE_W-1:0] resp_core,
  output logic [CORE_W-1:0] resp_owner,
  output logic [ADDR_W-1:0] resp_addr,
  output logic [DATA_W-1:0] resp_data
);
  logic              accept;
  logic              wr_en;
  logic              wr_reg;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              rd_reg;
  logic              p_valid;
  logic [1:0]        p_kind;
  logic [CORE_W-1:0] p_core;
  logic [ADDR_W-1:0] p_addr;

  always_ff @(posedge clk) begin
    if (rst) req_ready <= 1'b0;
    else     req_ready <= 1'b1;
  end

  assign accept = req_valid && req_ready;
  assign wr_reg = (req_kind == RQ_REG);
  assign wr_en  = accept && (wr_reg || req_kind == RQ_WB);
  // A registered word keeps the owner id in the low bits of its data slot.
  assign wr_data = wr_reg ? DATA_W'(req_core) : req_data;

  regbank_store #(.NWORDS(NWORDS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .en      (accept),
    .wr_en   (wr_en),
    .wr_reg  (wr_reg),
    .addr    (req_addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .rd_reg  (rd_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
      p_kind  <= RQ_READ;
      p_core  <= '0;
      p_addr  <= '0;
    end else begin
      p_valid <= accept;
      if (accept) begin
        p_kind <= req_kind;
        p_core <= req_core;
        p_addr <= req_addr;
      end
    end
  end

  regbank_resp #(.CORE_W(CORE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
    .clk        (clk),
    .rst        (rst),
    .p_valid    (p_valid),
    .p_kind     (p_kind),
    .p_core     (p_core),
    .p_addr     (p_addr),
    .p_reg      (rd_reg),
    .p_word     (rd_data),
    .resp_valid (resp_valid),
    .resp_kind  (resp_kind),
    .resp_core  (resp_core),
    .resp_owner (resp_owner),
    .resp_addr  (resp_addr),
    .resp_data  (resp_data)
  );
endmodule

// File: rtl/registry_bank_chk.sv
module registry_bank_chk #(
  parameter int CORE_W = 6,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic              resp_valid,
  input logic [1:0]        resp_kind,
  input logic [CORE_W-1:0] resp_core,
  input logic [CORE_W-1:0] resp_owner,
  input logic [DATA_W-1:0] resp_data
);
  AST_RESP_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
    resp_valid == $past(req_valid && req_ready, 2)); // R2

  AST_REG_ACKED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_kind == 2'd1) |=> ##1
      (resp_valid && resp_kind == 2'd1 && resp_owner == resp_core)); // R5

  AST_FWD_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_kind == 2'd2) |-> resp_data == '0); // R6

  AST_READ_ANSWER: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_kind == 2'd0 || req_kind == 2'd3)) |=> ##1
      (resp_valid && (resp_kind == 2'd0 || resp_kind == 2'd2))); // R4
endmodule

bind registry_bank registry_bank_chk #(.CORE_W(CORE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_kind   (req_kind),
  .resp_valid (resp_valid),
  .resp_kind  (resp_kind),
  .resp_core  (resp_core),
  .resp_owner (resp_owner),
  .resp_data  (resp_data)
);

// File: tb/sim_registry_bank.sv
module sim_registry_bank;
  localparam int NW = 8;
  localparam int CW = 6;
  localparam int DW = 16;
  localparam int AW = $clog2(NW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = '0;
  logic [CW-1:0] req_core = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic resp_valid;
  logic [1:0] resp_kind;
  logic [CW-1:0] resp_core, resp_owner;
  logic [AW-1:0] resp_addr;
  logic [DW-1:0] resp_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  registry_bank #(.NWORDS(NW), .CORE_W(CW), .DATA_W(DW)) u0 (.*);

  // Reference word model, updated in request order.
  bit          m_reg [NW];
  int          m_val [NW];
  int          m_own [NW];

  // Expected responses for the two requests in flight.
  bit    e_v [2];
  int    e_k [2], e_c [2], e_o [2], e_a [2], e_d [2];
  string e_t [2];

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle; compares the response owed by the request two cycles back.
  task automatic step(input bit v, input int kind, input int core, input int addr,
                      input int data, input string tag);
    @(negedge clk);
    check(resp_valid == e_v[1], e_t[1], "resp_valid", int'(resp_valid), int'(e_v[1]));
    if (e_v[1] && resp_valid) begin
      check(resp_kind == e_k[1] && resp_core == e_c[1] && resp_owner == e_o[1]
            && resp_addr == e_a[1] && resp_data == e_d[1], e_t[1],
            "kind/owner/data", int'(resp_kind) * 1000000 + int'(resp_owner) * 100000 + int'(resp_data),
            e_k[1] * 1000000 + e_o[1] * 100000 + e_d[1]);
    end
    e_v[1] = e_v[0]; e_k[1] = e_k[0]; e_c[1] = e_c[0]; e_o[1] = e_o[0];
    e_a[1] = e_a[0]; e_d[1] = e_d[0]; e_t[1] = e_t[0];
    e_v[0] = v; e_c[0] = core; e_a[0] = addr; e_t[0] = v ? tag : "R11";
    e_k[0] = 0; e_o[0] = 0; e_d[0] = 0;
    if (v) begin
      if (kind == 1) begin
        e_k[0] = 1; e_o[0] = core; m_reg[addr] = 1'b1; m_own[addr] = core;
      end else if (kind == 2) begin
        e_k[0] = 1; e_o[0] = core; m_reg[addr] = 1'b0; m_val[addr] = data;
      end else if (m_reg[addr]) begin
        e_k[0] = 2; e_o[0] = m_own[addr];
      end else begin
        e_d[0] = m_val[addr];
      end
    end
    req_valid = v;
    req_kind  = 2'(kind);
    req_core  = CW'(core);
    req_addr  = AW'(addr);
    req_data  = DW'(data);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      e_v[i] = 1'b0; e_t[i] = "R11";
    end
    repeat (3) @(negedge clk);
    check(resp_valid == 1'b0 && req_ready == 1'b0, "R1", "reset outputs",
          int'(resp_valid) * 2 + int'(req_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    // R3: fill every word
    for (int a = 0; a < NW; a++) step(1, 2, a + 10, a, a * 37 + 5, "R3");
    // R4: read every word, both read codes
    for (int a = 0; a < NW; a++) step(1, (a % 2 == 0) ? 0 : 3, 3, a, 0, "R4");
    // R11: idle cycles
    step(0, 0, 0, 0, 0, "R11");
    step(0, 1, 5, 1, 0, "R11");
    // R5: register even words to distinct cores
    for (int a = 0; a < NW; a += 2) step(1, 1, a + 1 + 50, a, 0, "R5");
    // R6, R9: read all; even forward, odd still data
    for (int a = 0; a < NW; a++) step(1, 0, 9, a, 0, (a % 2 == 0) ? "R6" : "R9");
    // R7: same owner re-registers
    step(1, 1, 51, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R11");
    step(1, 0, 2, 0, 0, "R7");
    // R8, R10: new owner then immediate read
    step(1, 1, 40, 2, 0, "R8");
    step(1, 0, 63, 2, 0, "R10");
    step(1, 1, 0, 2, 0, "R8");
    step(1, 0, 7, 2, 0, "R8");
    // R10: write-back then immediate read; register then immediate read
    step(1, 2, 40, 2, 16'hBEEF, "R10");
    step(1, 0, 1, 2, 0, "R10");
    step(1, 1, 33, 5, 0, "R10");
    step(1, 0, 1, 5, 0, "R10");
    step(1, 0, 1, 4, 0, "R9");
    // drain
    step(0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, "R11");
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule